// File: doc/BRIEF.md
# Thermal Clock Modulation Controller

This block throttles a core clock while a digital over-temperature flag is raised. When the monitor is enabled and the flag is present, it enters a throttling state. In that state its clock-gate enable output follows a fixed on/off pattern. Each modulation period opens with a run of on ticks and closes with a longer run of off ticks. The lengths are build-time parameters, so software cannot change the duty cycle. The pattern advances only on cycles where the free-running timebase strobe `tickEn` is high. This lets one fast clock serve several throttle rates.

When the flag drops, throttling does not stop at once. A hysteresis counter must first run down, counting only timebase ticks. If the flag comes back while the counter is running, the counter reloads. Once it expires, modulation ends at the next period boundary and the gate returns to a constant on. Interrupt requests that arrive while the clock is gated off are held, and are then presented for one cycle during an on phase. Snoop requests are acknowledged on the following cycle whatever the gate state.

Top module: `therm_throttle`

## Requirements
- R1: While throttling is inactive, `gateEn` is 1 and `throttleActive` is 0.
- R2: Throttling begins when `monEnable` and `overTemp` are both high at a clock edge. From the next cycle `throttleActive` is 1. The period starts with ON_TICKS timebase ticks of `gateEn`=1 (default 6), followed by PERIOD-ON_TICKS ticks of `gateEn`=0 (default 10 of 16). The phase moves only on cycles with `tickEn`=1.
- R3: With `monEnable` low, a high `overTemp` never starts throttling. Dropping `monEnable` during throttling counts as the condition having cleared.
- R4: After the condition clears, throttling stays active until HYST_TICKS timebase ticks (default 32) have passed without the condition. A return of the condition reloads that count.
- R5: Throttling ends only on a `tickEn` cycle that completes the last tick of a period, once the hysteresis count is zero. On the next cycle `throttleActive` is 0 and `gateEn` is 1.
- R6: A request on bit i of `irqIn` appears on bit i of `irqOut` in the first cycle after arrival in which `gateEn` is 1, for exactly that one cycle. While `gateEn` is 0, `irqOut` is 0 and requests stay pending.
- R7: `snoopAck` equals the value `snoopReq` had one cycle earlier, whether the gate is on or off.
- R8: After reset, `throttleActive`=0, `gateEn`=1, `irqOut`=0 and `snoopAck`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| monEnable | input | 1 | Thermal monitor enable |
| overTemp | input | 1 | Synchronous over-temperature flag |
| tickEn | input | 1 | Timebase strobe that advances phase and hysteresis |
| irqIn | input | IRQ_W | Interrupt request pulses |
| snoopReq | input | 1 | Snoop request |
| gateEn | output | 1 | Clock-gate enable (1 = clock runs) |
| throttleActive | output | 1 | Throttling state |
| irqOut | output | IRQ_W | Interrupts presented to the core |
| snoopAck | output | 1 | Snoop acknowledge |

## Verification
The hardest case to reach from the ports is an exit that lands exactly on a period boundary after a reloaded hysteresis count, while the timebase strobe is sparse. The stimulus gets there by clearing the flag and then raising it again for a single cycle partway through the countdown. The run is repeated with `tickEn` high only one cycle in three. Interrupt pulses arrive during off phases and just before phase changes, so the held-bit path is exercised at both edges of the on window.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  typedef struct packed {
    logic active;    // throttling state
    logic phaseClr;  // force phase to the period start
    logic phaseAdv;  // advance phase by one tick
  } strobe_t;
endpackage

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
#(
  parameter int HYST_TICKS = 32,
  localparam int HY_W = $clog2(HYST_TICKS + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    monEnable,
  input  logic    overTemp,
  input  logic    tickEn,
  input  logic    phaseLast,
  output strobe_t st
);
  logic hot;
  logic activeQ;
  logic exitNow;
  logic [HY_W-1:0] hystCnt;

  assign hot     = monEnable & overTemp;
  assign exitNow = activeQ & ~hot & (hystCnt == '0) & tickEn & phaseLast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
    end else if (!activeQ) begin
      activeQ <= hot;
    end else begin
      activeQ <= ~exitNow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hystCnt <= '0;
    end else if (hot) begin
      hystCnt <= HY_W'(HYST_TICKS);
    end else if (!activeQ) begin
      hystCnt <= '0;
    end else if (tickEn && hystCnt != '0) begin
      hystCnt <= hystCnt - 1'b1;
    end
  end

  always_comb begin
    st.active   = activeQ;
    st.phaseClr = ~activeQ | exitNow;
    st.phaseAdv = activeQ & tickEn;
  end

  // R1 / R3: no entry without an enabled over-temperature condition
  p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!activeQ && !hot) |=> !activeQ);
  // R4: a present condition keeps throttling on
  p_hold_hot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && hot) |=> activeQ);
  // R4: a running hysteresis count forbids exit
  p_hyst_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && hystCnt != '0) |=> activeQ);
endmodule

// File: rtl/throttle_dpath.sv
module throttle_dpath
  import throttle_pkg::*;
#(
  parameter int PERIOD   = 16,
  parameter int ON_TICKS = 6,
  parameter int IRQ_W    = 4,
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          st,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic             snoopReq,
  output logic             phaseLast,
  output logic             gateEn,
  output logic [IRQ_W-1:0] irqOut,
  output logic             snoopAck
);
  logic [PH_W-1:0] phaseCnt;
  logic [IRQ_W-1:0] pending;

  assign phaseLast = (phaseCnt == PH_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (st.phaseClr) begin
      phaseCnt <= '0;
    end else if (st.phaseAdv) begin
      phaseCnt <= phaseLast ? '0 : phaseCnt + 1'b1;
    end
  end

  assign gateEn = ~st.active | (32'(phaseCnt) < ON_TICKS);

  // one held request bit per interrupt line
  for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
      end else begin
        pending[i] <= (pending[i] & ~gateEn) | irqIn[i];
      end
    end
    assign irqOut[i] = pending[i] & gateEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoopAck <= 1'b0;
    end else begin
      snoopAck <= snoopReq;
    end
  end

  // R2: every throttle episode opens in the on phase
  p_start_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.active) |-> gateEn);
  // R5: exit only right after the last tick of a period
  p_exit_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st.active) |-> $past(phaseLast));
  // R6: held bits survive an off cycle
  p_pend_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gateEn && pending != '0) |=> ((pending & $past(pending)) == $past(pending)));
  // R7: snoops answered regardless of gate
  p_snoop_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snoopReq |=> snoopAck);
endmodule

// File: rtl/therm_throttle.sv
module therm_throttle
  import throttle_pkg::*;
#(
  parameter int PERIOD     = 16,
  parameter int ON_TICKS   = 6,
  parameter int HYST_TICKS = 32,
  parameter int IRQ_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             monEnable,
  input  logic             overTemp,
  input  logic             tickEn,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic             snoopReq,
  output logic             gateEn,
  output logic             throttleActive,
  output logic [IRQ_W-1:0] irqOut,
  output logic             snoopAck
);
  strobe_t st;
  logic phaseLast;

  throttle_ctrl #(.HYST_TICKS(HYST_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .monEnable(monEnable), .overTemp(overTemp),
    .tickEn(tickEn), .phaseLast(phaseLast), .st(st)
  );

  throttle_dpath #(.PERIOD(PERIOD), .ON_TICKS(ON_TICKS), .IRQ_W(IRQ_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .st(st), .irqIn(irqIn), .snoopReq(snoopReq),
    .phaseLast(phaseLast), .gateEn(gateEn), .irqOut(irqOut), .snoopAck(snoopAck)
  );

  assign throttleActive = st.active;
endmodule

// File: tb/tb_therm_throttle.sv
module tb_therm_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 16, ON_TICKS = 6, HYST_TICKS = 32, IRQ_W = 4;

  logic clk = 0, rst_n = 0;
  logic monEnable = 0, overTemp = 0, tickEn = 0, snoopReq = 0;
  logic [IRQ_W-1:0] irqIn = '0;
  logic gateEn, throttleActive, snoopAck;
  logic [IRQ_W-1:0] irqOut;

  therm_throttle #(.PERIOD(PERIOD), .ON_TICKS(ON_TICKS), .HYST_TICKS(HYST_TICKS), .IRQ_W(IRQ_W)) dut (
    .clk(clk), .rst_n(rst_n), .monEnable(monEnable), .overTemp(overTemp), .tickEn(tickEn),
    .irqIn(irqIn), .snoopReq(snoopReq), .gateEn(gateEn), .throttleActive(throttleActive),
    .irqOut(irqOut), .snoopAck(snoopAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nRun = 0, nFail = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  int mActive = 0, mPhase = 0, mHyst = 0, mPend = 0, mSnoop = 0;

  function automatic int mGate();
    return (mActive == 0 || mPhase < ON_TICKS) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int hot, exitNow, g;
      hot = (monEnable && overTemp) ? 1 : 0;
      g = mGate();
      exitNow = (mActive && !hot && mHyst == 0 && tickEn && mPhase == PERIOD-1) ? 1 : 0;
      mPend = (g ? 0 : mPend) | int'(irqIn);
      mSnoop = int'(snoopReq);
      if (hot) mHyst = HYST_TICKS;
      else if (!mActive) mHyst = 0;
      else if (tickEn && mHyst > 0) mHyst--;
      if (!mActive || exitNow) mPhase = 0;
      else if (tickEn) mPhase = (mPhase + 1) % PERIOD;
      mActive = mActive ? (exitNow ? 0 : 1) : hot;
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      chk("R2 throttleActive", int'(throttleActive), mActive);
      chk("R5 gateEn", int'(gateEn), mGate());
      chk("R6 irqOut", int'(irqOut), mGate() ? mPend : 0);
      chk("R7 snoopAck", int'(snoopAck), mSnoop);
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  int tickDiv = 1;
  int tickPh = 0;
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickPh = (tickPh + 1) % tickDiv;
      tickEn = (tickPh == 0);
      irqIn = ($urandom_range(0, 5) == 0) ? IRQ_W'($urandom_range(1, (1 << IRQ_W) - 1)) : '0;
      snoopReq = ($urandom_range(0, 2) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    chk("R8 throttleActive", int'(throttleActive), 0);
    chk("R8 gateEn", int'(gateEn), 1);
    chk("R8 irqOut", int'(irqOut), 0);
    chk("R8 snoopAck", int'(snoopAck), 0);
    rst_n = 1;
    step(5);
    // R3: disabled monitor ignores over-temperature
    overTemp = 1;
    step(40);
    chk("R3 no throttle when disabled", int'(throttleActive), 0);
    chk("R1 gate on when inactive", int'(gateEn), 1);
    // R2: enabled and hot
    monEnable = 1;
    step(100);
    chk("R2 throttling", int'(throttleActive), 1);
    // R4: clear, re-raise once mid countdown
    overTemp = 0;
    step(20);
    chk("R4 held by hysteresis", int'(throttleActive), 1);
    overTemp = 1;
    step(1);
    overTemp = 0;
    step(25);
    chk("R4 reload keeps throttling", int'(throttleActive), 1);
    step(60);
    chk("R5 exited at boundary", int'(throttleActive), mActive);
    chk("R1 gate on after exit", int'(gateEn), 1);
    // sparse timebase
    tickDiv = 3;
    step(10);
    overTemp = 1;
    step(120);
    chk("R2 sparse throttling", int'(throttleActive), 1);
    overTemp = 0;
    step(40);
    overTemp = 1;
    step(2);
    overTemp = 0;
    step(200);
    // R3: drop enable while throttling
    tickDiv = 1;
    overTemp = 1;
    step(30);
    monEnable = 0;
    step(90);
    chk("R3 enable drop ends throttling", int'(throttleActive), 0);
    step(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule